// File: doc/BRIEF.md
# Cut-Tree Leaf Finder

This block locates the leaf bucket of a multi-level cut decision tree for one packet header. The tree lives in an internal node memory that is filled through a simple write port. Each stored node is one of two kinds. An inner node carries the base address of its block of children and one cut count per dimension. A leaf carries a pointer into a separate leaf table. A lookup starts from a programmable set of top-level cut counts, with the root's children at node address 0. At each level the engine forms a child offset from fresh header bits and reads one node. It continues until it reads a leaf. It then reports the leaf pointer with a one-cycle completion pulse.

Four header dimensions take part in indexing: source address, destination address, source port and destination port. A cut count of n splits its dimension into 2^n slices. Across levels, each dimension keeps its own count of bits already consumed, so deeper levels look at finer bits. The protocol byte is accepted but plays no part. A depth limit bounds the number of node reads per lookup. Comparing rules against the header, building the tree and choosing the cuts are done elsewhere.

Top module: `cut_tree_walker`

## Requirements
- R1: After reset, busy, done and fault are 0 and leaf_ptr is 0.
- R2: A node word has the pointer field in bits [28:19], the leaf flag in bit 18 (1 = leaf, 0 = inner), and the cut counts in bits [17:0]: source address [17:13], destination address [12:8], source port [7:4], destination port [3:0]. When wr_en is high at a clock edge, wr_data is stored at node wr_addr.
- R3: The first node read of a lookup uses init_shifts (same field layout as bits [17:0] of a node word) as its cut counts, with 0 as the base address and no header bits consumed.
- R4: The child node address is (base + offset) mod 2^NODE_AW. The offset is the concatenation, most significant part first, of source address, destination address, source port and destination port slices. Each slice is the next k unread most-significant bits of its field, where k is that dimension's cut count. Bit positions past the end of a field read as 0.
- R5: After every node read, each dimension's consumed-bit count grows by the cut count used in that read, so the next level takes the bits that follow.
- R6: hdr_proto has no effect on any output.
- R7: If the start cycle is sampled at edge 0 and the L-th node read returns a leaf, done is high for exactly the cycle after edge L. In that cycle fault is 0 and leaf_ptr equals that leaf's pointer field. One node is read per level.
- R8: If MAX_DEPTH node reads (5 by default) all return inner nodes, done and fault are both high for the cycle after edge MAX_DEPTH and leaf_ptr is 0. A leaf found by read number MAX_DEPTH is still reported normally.
- R9: busy is high from edge 0 until the edge that raises done. A start pulse while busy is ignored and leaves the running lookup unchanged.
- R10: done is a single-cycle pulse, and leaf_ptr holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_shifts | input | 18 | Top-level cut counts |
| start | input | 1 | Begin a lookup (taken when idle) |
| hdr_sa | input | 32 | Source address |
| hdr_da | input | 32 | Destination address |
| hdr_sp | input | 16 | Source port |
| hdr_dp | input | 16 | Destination port |
| hdr_proto | input | 8 | Protocol byte (unused for indexing) |
| wr_en | input | 1 | Node memory write enable |
| wr_addr | input | NODE_AW (8) | Node memory write address |
| wr_data | input | PTR_W+19 (29) | Node word to store |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Depth limit hit, valid with done |
| leaf_ptr | output | PTR_W (10) | Leaf table pointer |

## Verification
The headers are chosen so that each lookup selects a different root child. One sets only the top destination-address bit and one sets only a top source-address bit, which separates the slice order of the concatenation. A destination-port slice that carries the base past the top of memory checks the modulo wrap. A two-level source-port walk whose second cut runs past bit 0 checks both the consumed-bit carry between levels and the zero fill. Two inner-node chains, one ending in a leaf at exactly the depth limit and one that never ends, separate a correct limit from an off-by-one. Repeating a header with another protocol byte, and pulsing start mid-walk, must leave the result and its timing unchanged.

// File: rtl/cut_tree_pkg.sv
package cut_tree_pkg;

  localparam int SHF_W = 18;

  // Per-level cut counts; packing order sets the bit positions in a node word.
  typedef struct packed {
    logic [4:0] sa;
    logic [4:0] da;
    logic [3:0] sp;
    logic [3:0] dp;
  } cut_shifts_t;

  // Bits already consumed per dimension.
  typedef struct packed {
    logic [7:0] sa;
    logic [7:0] da;
    logic [7:0] sp;
    logic [7:0] dp;
  } cut_used_t;

  // Next n unread MSBs of a 32-bit field, right aligned; reads past the end give 0.
  function automatic logic [31:0] take_msbs32(logic [31:0] f, logic [7:0] used, logic [4:0] n);
    logic [31:0] t;
    t = f << used;
    if (n == 5'd0) return '0;
    return t >> (6'd32 - {1'b0, n});
  endfunction

  function automatic logic [15:0] take_msbs16(logic [15:0] f, logic [7:0] used, logic [3:0] n);
    logic [15:0] t;
    t = f << used;
    if (n == 4'd0) return '0;
    return t >> (5'd16 - {1'b0, n});
  endfunction

  function automatic logic [7:0] sat_add8(logic [7:0] a, logic [4:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {4'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic cut_used_t advance_used(cut_used_t u, cut_shifts_t s);
    cut_used_t r;
    r.sa = sat_add8(u.sa, s.sa);
    r.da = sat_add8(u.da, s.da);
    r.sp = sat_add8(u.sp, {1'b0, s.sp});
    r.dp = sat_add8(u.dp, {1'b0, s.dp});
    return r;
  endfunction

endpackage

// File: rtl/cut_node_ram.sv
module cut_node_ram #(
  parameter int AW = 8,
  parameter int DW = 29
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cut_child_index.sv
module cut_child_index
  import cut_tree_pkg::*;
#(
  parameter int NODE_AW = 8
) (
  input  logic [NODE_AW-1:0] base,
  input  cut_shifts_t        shifts,
  input  cut_used_t          used,
  input  logic [31:0]        f_sa,
  input  logic [31:0]        f_da,
  input  logic [15:0]        f_sp,
  input  logic [15:0]        f_dp,
  output logic [NODE_AW-1:0] child
);
  logic [31:0]        b_sa, b_da;
  logic [15:0]        b_sp, b_dp;
  logic [NODE_AW-1:0] acc;

  always_comb begin
    b_sa = take_msbs32(f_sa, used.sa, shifts.sa);
    b_da = take_msbs32(f_da, used.da, shifts.da);
    b_sp = take_msbs16(f_sp, used.sp, shifts.sp);
    b_dp = take_msbs16(f_dp, used.dp, shifts.dp);
    // Concatenate modulo 2^NODE_AW: shift then merge each slice in turn.
    acc = NODE_AW'(b_sa);
    acc = (acc << shifts.da) | NODE_AW'(b_da);
    acc = (acc << shifts.sp) | NODE_AW'(b_sp);
    acc = (acc << shifts.dp) | NODE_AW'(b_dp);
    child = base + acc;
  end
endmodule

// File: rtl/cut_tree_walker.sv
module cut_tree_walker
  import cut_tree_pkg::*;
#(
  parameter int NODE_AW   = 8,
  parameter int PTR_W     = 10,
  parameter int MAX_DEPTH = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [17:0]          init_shifts,
  input  logic                 start,
  input  logic [31:0]          hdr_sa,
  input  logic [31:0]          hdr_da,
  input  logic [15:0]          hdr_sp,
  input  logic [15:0]          hdr_dp,
  input  logic [7:0]           hdr_proto,
  input  logic                 wr_en,
  input  logic [NODE_AW-1:0]   wr_addr,
  input  logic [PTR_W+18:0]    wr_data,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [PTR_W-1:0]     leaf_ptr
);
  localparam int ENT_W   = PTR_W + 1 + SHF_W;
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
  localparam logic [DEPTH_W-1:0] DEPTH_LIM = DEPTH_W'(MAX_DEPTH);

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;

  walk_st_t             state_q;
  logic [31:0]          sa_q, da_q;
  logic [15:0]          sp_q, dp_q;
  cut_used_t            used_q;
  logic [DEPTH_W-1:0]   depth_q;
  logic                 done_q, fault_q;
  logic [PTR_W-1:0]     ptr_q;

  logic [ENT_W-1:0]     rd_data;
  logic [PTR_W-1:0]     ent_ptr;
  logic                 ent_leaf;
  cut_shifts_t          ent_shf;

  // Named events for the checker.
  logic                 in_walk, accept, leaf_seen, depth_abort, lvl_issue;

  logic [NODE_AW-1:0]   sel_base, child_addr;
  cut_shifts_t          sel_shf;
  cut_used_t            sel_used, next_used;
  logic [31:0]          sel_sa, sel_da;
  logic [15:0]          sel_sp, sel_dp;
  logic                 unused_proto;

  assign unused_proto = ^hdr_proto;

  assign ent_ptr  = rd_data[ENT_W-1 -: PTR_W];
  assign ent_leaf = rd_data[SHF_W];
  assign ent_shf  = cut_shifts_t'(rd_data[SHF_W-1:0]);

  assign in_walk     = (state_q == ST_WALK);
  assign accept      = !in_walk && start;
  assign leaf_seen   = in_walk && ent_leaf;
  assign depth_abort = in_walk && !ent_leaf && (depth_q == DEPTH_LIM);
  assign lvl_issue   = accept || (in_walk && !ent_leaf && !depth_abort);

  // One index generator, fed by the start inputs or by the node just read.
  always_comb begin
    if (in_walk) begin
      sel_base = ent_ptr[NODE_AW-1:0];
      sel_shf  = ent_shf;
      sel_used = used_q;
      sel_sa   = sa_q;
      sel_da   = da_q;
      sel_sp   = sp_q;
      sel_dp   = dp_q;
    end else begin
      sel_base = '0;
      sel_shf  = cut_shifts_t'(init_shifts);
      sel_used = '0;
      sel_sa   = hdr_sa;
      sel_da   = hdr_da;
      sel_sp   = hdr_sp;
      sel_dp   = hdr_dp;
    end
    next_used = advance_used(sel_used, sel_shf);
  end

  cut_child_index #(.NODE_AW(NODE_AW)) u_index (
    .base   (sel_base),
    .shifts (sel_shf),
    .used   (sel_used),
    .f_sa   (sel_sa),
    .f_da   (sel_da),
    .f_sp   (sel_sp),
    .f_dp   (sel_dp),
    .child  (child_addr)
  );

  cut_node_ram #(.AW(NODE_AW), .DW(ENT_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (lvl_issue),
    .rd_addr (child_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sa_q    <= '0;
      da_q    <= '0;
      sp_q    <= '0;
      dp_q    <= '0;
      used_q  <= '0;
      depth_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        state_q <= ST_WALK;
        sa_q    <= hdr_sa;
        da_q    <= hdr_da;
        sp_q    <= hdr_sp;
        dp_q    <= hdr_dp;
        used_q  <= next_used;
        depth_q <= DEPTH_W'(1);
      end else if (in_walk) begin
        if (leaf_seen) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          ptr_q   <= ent_ptr;
        end else if (depth_abort) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          fault_q <= 1'b1;
          ptr_q   <= '0;
        end else begin
          used_q  <= next_used;
          depth_q <= depth_q + DEPTH_W'(1);
        end
      end
    end
  end

  assign busy     = in_walk;
  assign done     = done_q;
  assign fault    = fault_q;
  assign leaf_ptr = ptr_q;
endmodule

// File: rtl/cut_tree_walker_chk.sv
module cut_tree_walker_chk #(
  parameter int PTR_W   = 10,
  parameter int DEPTH_W = 3,
  parameter int MAX_DEPTH = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fault,
  input logic [PTR_W-1:0]   leaf_ptr,
  input logic [PTR_W-1:0]   ent_ptr,
  input logic               leaf_seen,
  input logic               depth_abort,
  input logic               lvl_issue,
  input logic [DEPTH_W-1:0] depth_q
);
  localparam logic [DEPTH_W-1:0] LIM = DEPTH_W'(MAX_DEPTH);

  AST_LEAF_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_seen |=> (done && !fault && leaf_ptr == $past(ent_ptr))); // R7
  AST_READ_PER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !leaf_seen && !depth_abort) |-> lvl_issue); // R7
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    depth_abort |=> (done && fault && leaf_ptr == '0)); // R8
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R8
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (depth_q != '0 && depth_q <= LIM)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !leaf_seen && !depth_abort) |=> (busy && depth_q == $past(depth_q) + DEPTH_W'(1))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(leaf_ptr)); // R10
endmodule

bind cut_tree_walker cut_tree_walker_chk #(
  .PTR_W(PTR_W), .DEPTH_W(DEPTH_W), .MAX_DEPTH(MAX_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .leaf_ptr(leaf_ptr), .ent_ptr(ent_ptr), .leaf_seen(leaf_seen),
  .depth_abort(depth_abort), .lvl_issue(lvl_issue), .depth_q(depth_q)
);

// File: tb/test_cut_tree_walker.sv
`timescale 1ns/1ps
module test_cut_tree_walker;
  localparam int AW = 8;
  localparam int PW = 10;
  localparam int MAXD = 5;
  localparam int NN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] init_shifts = '0;
  logic start = 1'b0;
  logic [31:0] hdr_sa = '0, hdr_da = '0;
  logic [15:0] hdr_sp = '0, hdr_dp = '0;
  logic [7:0] hdr_proto = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [PW+18:0] wr_data = '0;
  logic busy, done, fault;
  logic [PW-1:0] leaf_ptr;

  always #2 clk = ~clk;

  cut_tree_walker #(.NODE_AW(AW), .PTR_W(PW), .MAX_DEPTH(MAXD)) i_cut_tree_walker (
    .clk(clk), .rst_n(rst_n), .init_shifts(init_shifts), .start(start),
    .hdr_sa(hdr_sa), .hdr_da(hdr_da), .hdr_sp(hdr_sp), .hdr_dp(hdr_dp),
    .hdr_proto(hdr_proto), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .fault(fault), .leaf_ptr(leaf_ptr)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Behavioural mirror of the node memory.
  int  m_ptr [NN];
  bit  m_leaf[NN];
  int  m_cut [NN][4];
  int  ini[4];

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_node(int a, int p, bit lf, int c0, int c1, int c2, int c3);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = {PW'(p), lf, 5'(c0), 5'(c1), 4'(c2), 4'(c3)};
    m_ptr[a] = p; m_leaf[a] = lf;
    m_cut[a][0] = c0; m_cut[a][1] = c1; m_cut[a][2] = c2; m_cut[a][3] = c3;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_init(int c0, int c1, int c2, int c3);
    ini[0] = c0; ini[1] = c1; ini[2] = c2; ini[3] = c3;
    init_shifts = {5'(c0), 5'(c1), 4'(c2), 4'(c3)};
  endtask

  // Bit k (counting from the MSB) of a field, 0 past its end.
  function automatic int msb_bit(longint f, int w, int k);
    if (k >= w) return 0;
    return int'((f >> (w - 1 - k)) & 1);
  endfunction

  task automatic model_walk(longint f0, longint f1, longint f2, longint f3,
                            output int lv, output int ptr, output bit flt);
    int base = 0;
    int cuts[4];
    int used[4] = '{0, 0, 0, 0};
    int widths[4] = '{32, 32, 16, 16};
    longint fld[4];
    fld[0] = f0; fld[1] = f1; fld[2] = f2; fld[3] = f3;
    for (int d = 0; d < 4; d++) cuts[d] = ini[d];
    flt = 0; ptr = 0; lv = MAXD;
    for (int lvl = 1; lvl <= MAXD; lvl++) begin
      int off = 0;
      int node;
      for (int d = 0; d < 4; d++) begin
        for (int k = 0; k < cuts[d]; k++)
          off = (off * 2 + msb_bit(fld[d], widths[d], used[d] + k)) % NN;
        used[d] += cuts[d];
      end
      node = (base + off) % NN;
      if (m_leaf[node]) begin
        lv = lvl; ptr = m_ptr[node];
        return;
      end
      base = m_ptr[node] % NN;
      for (int d = 0; d < 4; d++) cuts[d] = m_cut[node][d];
    end
    flt = 1;
  endtask

  // Drive one lookup and compare against the model on every clock.
  task automatic run_lookup(string req, longint sa, longint da, longint sp, longint dp,
                            int proto, bit poke, output int got_ptr);
    int lv, eptr;
    bit eflt;
    model_walk(sa, da, sp, dp, lv, eptr, eflt);
    @(negedge clk);
    hdr_sa = 32'(sa); hdr_da = 32'(da); hdr_sp = 16'(sp); hdr_dp = 16'(dp);
    hdr_proto = 8'(proto);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < lv; k++) begin
      check("R9", "busy during walk", busy, 1);
      check(req, "done early", done, 0);
      if (poke && k == 0) begin
        start = 1'b1;
        hdr_sa = ~hdr_sa; hdr_da = ~hdr_da; hdr_sp = ~hdr_sp; hdr_dp = ~hdr_dp;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(req, "done at completion", done, 1);
    check("R9", "busy at completion", busy, 0);
    check(eflt ? "R8" : req, "fault", fault, eflt);
    check(req, "leaf_ptr", leaf_ptr, eptr);
    got_ptr = int'(leaf_ptr);
    @(negedge clk);
    check("R10", "done pulse width", done, 0);
    check("R10", "leaf_ptr held", leaf_ptr, eptr);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p1, p2;
    set_init(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "fault after reset", fault, 0);
    check("R1", "leaf_ptr after reset", leaf_ptr, 0);

    for (int a = 0; a < NN; a++) put_node(a, 500 + a, 1'b1, 0, 0, 0, 0);

    // R3: no top-level cuts, root child is node 0.
    put_node(0, 100, 1'b1, 0, 0, 0, 0);
    run_lookup("R3", 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF, 64'hFFFF, 0, 0, p1);
    // R2: rewrite node 0 through the write port.
    put_node(0, 777, 1'b1, 0, 0, 0, 0);
    run_lookup("R2", 0, 0, 0, 0, 0, 0, p1);

    // Two-level tree, root offset = {sa[31:30], da[31]}.
    put_node(0, 100, 1'b1, 0, 0, 0, 0);
    put_node(1, 101, 1'b1, 0, 0, 0, 0);
    put_node(4, 104, 1'b1, 0, 0, 0, 0);
    put_node(2, 250, 1'b0, 0, 0, 0, 4);
    put_node(3, 80, 1'b0, 0, 0, 15, 0);
    put_node(81, 90, 1'b0, 0, 0, 4, 0);
    put_node(5, 16, 1'b0, 1, 0, 2, 1);
    put_node(6, 60, 1'b0, 0, 0, 0, 0);
    for (int a = 60; a < 64; a++) put_node(a, a + 1, 1'b0, 0, 0, 0, 0);
    put_node(7, 70, 1'b0, 0, 0, 0, 0);
    for (int a = 70; a < 73; a++) put_node(a, a + 1, 1'b0, 0, 0, 0, 0);
    put_node(73, 333, 1'b1, 0, 0, 0, 0);
    set_init(2, 1, 0, 0);

    run_lookup("R4", 64'h0000_0000, 64'h8000_0000, 0, 0, 0, 0, p1);      // node 1
    run_lookup("R4", 64'h8000_0000, 64'h0000_0000, 0, 0, 0, 0, p1);      // node 4
    run_lookup("R4", 64'h4000_0000, 64'h0000_0000, 0, 64'hF000, 0, 0, p1); // wrap to 9
    run_lookup("R5", 64'h4000_0000, 64'h8000_0000, 64'h0003, 0, 0, 0, p1); // 3->81->98
    run_lookup("R5", 64'hA000_0000, 64'h8000_0000, 64'h4000, 64'h8000, 6, 0, p1); // 5->27
    run_lookup("R6", 64'hA000_0000, 64'h8000_0000, 64'h4000, 64'h8000, 17, 0, p2);
    check("R6", "protocol changes result", p2, p1);
    run_lookup("R9", 64'hA000_0000, 64'h8000_0000, 64'h4000, 64'h8000, 0, 1, p2);
    check("R9", "start while busy altered result", p2, p1);
    run_lookup("R8", 64'hC000_0000, 64'h8000_0000, 0, 0, 0, 1, p1);      // leaf at read 5
    check("R8", "leaf at depth limit", p1, 333);
    run_lookup("R8", 64'hC000_0000, 64'h0000_0000, 0, 0, 0, 0, p1);      // abort
    check("R8", "abort pointer", p1, 0);
    run_lookup("R7", 64'h8000_0000, 64'h0000_0000, 0, 0, 0, 0, p1);
    check("R7", "single level pointer", p1, 104);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule